// File: doc/BRIEF.md
# Processor-Side Mailbox Queue

This block is the processor-facing end of a one-way message mailbox. A producer on the far side appends 32-bit words through a fill port. The processor drains them through a small memory-mapped register window. Reading the pop register returns the oldest word and removes it. Reading the peek register returns the oldest word and leaves it in place. A status register reports whether the queue is full or empty and how many words it holds. A config register holds one interrupt enable bit and shows whether data is waiting.

The queue keeps its words in a shift-down store. On every removal all words move one slot toward the head, and the freed top slot is refilled with a fixed invalid-data sentinel. Any empty slot, including the head of an empty queue, therefore reads as the sentinel. The block passes through a status word for a second, opposite-direction queue so that software can poll both from one window. It raises a level interrupt while data is waiting and the enable bit is set.

The register bus has no wait states. A read returns its data in the same cycle as the access, and any pop takes effect at the clock edge that ends that cycle.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset the queue holds no words, every slot holds the sentinel (default 32'hFFFFFFFF), config reads 0, `irq` is 0 and `fill_ready` is 1.
- R2: A fill while `fill_ready` is 1 appends `fill_data` behind the newest word. `fill_ready` is 0 exactly when the queue holds DEPTH words. A fill offered while full is dropped and changes nothing.
- R3: A read at word offset 0x80, 0x84, 0x88 or 0x8C of a non-empty queue returns the oldest word in that cycle and removes it. Words leave in the order they arrived.
- R4: A read at a pop offset while the queue is empty returns the sentinel and leaves the queue and its status unchanged.
- R5: A read at offset 0x90 returns the oldest word without removing it. On an empty queue it returns the sentinel.
- R6: A read at offset 0x98 returns bit 31 = full (count equals DEPTH), bit 30 = empty (count zero), bits 7:0 = current count, and all other bits 0.
- R7: A read at offset 0x9C returns bit 0 = interrupt enable and bit 4 = data waiting (count non-zero), with all other bits 0. A write there updates only bit 0 from `bus_wdata[0]`.
- R8: `irq` is a registered output. After each clock edge it equals (enable AND count non-zero) for the state that edge produced.
- R9: A read at offset 0xB8 returns `peer_status`.
- R10: Only address bits 7:0 select a register. Offset 0x94, unaligned offsets and all unlisted offsets read as 0. Writes anywhere except 0x9C, including writes to the pop offsets, have no effect.
- R11: A fill and a pop in the same cycle on a non-empty queue both take effect. The popped word is returned, the count is unchanged, and the filled word lands behind the survivors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| fill_valid | input | 1 | Producer offers a word |
| fill_data | input | 32 | Word to append |
| fill_ready | output | 1 | Queue has space |
| peer_status | input | 32 | Status word of the opposite-direction queue |
| irq | output | 1 | Level interrupt: data waiting and enabled |

## Verification
A wrong count in the queue shows up on the status read in the same cycle as the access. It also shows on `fill_ready` and, one edge later, on `irq`. A broken shift or a missed sentinel refill appears as a wrong or out-of-order word on the very next pop or peek, or as stale data in place of the sentinel once the queue drains. The bench therefore walks the fill level through every value from empty to full and back on a four-deep queue. At each level it compares status, peek and pop against arithmetic expectations.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W = 32;

    localparam logic [7:0] OFF_PEEK = 8'h90;
    localparam logic [7:0] OFF_STAT = 8'h98;
    localparam logic [7:0] OFF_CFG  = 8'h9C;
    localparam logic [7:0] OFF_PEER = 8'hB8;

    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_PEND_BIT   = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POP,
        SEL_PEEK,
        SEL_STAT,
        SEL_CFG,
        SEL_PEER
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [7:0] off);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (off[1:0] == 2'b00) begin
            if (off[7:4] == 4'h8) begin
                sel = SEL_POP;
            end else begin
                case (off)
                    OFF_PEEK: sel = SEL_PEEK;
                    OFF_STAT: sel = SEL_STAT;
                    OFF_CFG:  sel = SEL_CFG;
                    OFF_PEER: sel = SEL_PEER;
                    default:  sel = SEL_NONE;
                endcase
            end
        end
        return sel;
    endfunction
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int                  DEPTH    = 8,
    parameter int                  DW       = 32,
    parameter logic [DW-1:0]       SENTINEL = '1,
    localparam int                 CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic [DW-1:0] push_word,
    input  logic          pop_en,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count_q,
    output logic [CW-1:0] count_d
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slot;
        logic [CW-1:0]            cnt;
    } store_t;

    store_t s_d, s_q;
    logic [CW-1:0] wr_idx;

    always_comb begin
        s_d    = s_q;
        wr_idx = s_q.cnt;
        if (pop_en) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                s_d.slot[i] = s_q.slot[i + 1];
            end
            s_d.slot[DEPTH-1] = SENTINEL;
            s_d.cnt           = s_q.cnt - CW'(1);
            wr_idx            = s_q.cnt - CW'(1);
        end
        if (push_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == CW'(i)) begin
                    s_d.slot[i] = push_word;
                end
            end
            s_d.cnt = s_d.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.slot <= {DEPTH{SENTINEL}};
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head    = s_q.slot[0];
    assign count_q = s_q.cnt;
    assign count_d = s_d.cnt;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    p_top_sentinel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q < CW'(DEPTH)) |-> (s_q.slot[DEPTH-1] == SENTINEL));

    p_pop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && !push_en) |=> (count_q == $past(count_q) - CW'(1)));

    p_both_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && push_en) |=> $stable(count_q));
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int                  DEPTH    = 8,
    parameter int                  ADDR_W   = 12,
    parameter logic [WORD_W-1:0]   SENTINEL = '1,
    localparam int                 CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en_bit,
    input  logic [WORD_W-1:0] head,
    input  logic [CW-1:0]     count_q,
    input  logic [CW-1:0]     count_d,
    input  logic [WORD_W-1:0] peer_status,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              pop_en,
    output logic              irq
);
    typedef struct packed {
        logic en;
        logic irq;
    } ctl_t;

    ctl_t     c_d, c_q;
    reg_sel_e sel;
    logic     waiting;
    logic     full;

    assign sel     = decode_off(bus_addr[7:0]);
    assign waiting = (count_q != '0);
    assign full    = (count_q == CW'(DEPTH));
    assign pop_en  = bus_valid && !bus_write && (sel == SEL_POP) && waiting;

    always_comb begin
        c_d = c_q;
        if (bus_valid && bus_write && (sel == SEL_CFG)) begin
            c_d.en = wr_en_bit;
        end
        c_d.irq = c_d.en && (count_d != '0);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (sel)
                SEL_POP:  bus_rdata = waiting ? head : SENTINEL;
                SEL_PEEK: bus_rdata = head;
                SEL_STAT: begin
                    bus_rdata[STAT_FULL_BIT]  = full;
                    bus_rdata[STAT_EMPTY_BIT] = !waiting;
                    bus_rdata[7:0]            = 8'(count_q);
                end
                SEL_CFG: begin
                    bus_rdata[CFG_EN_BIT]   = c_q.en;
                    bus_rdata[CFG_PEND_BIT] = waiting;
                end
                SEL_PEER: bus_rdata = peer_status;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign irq = c_q.irq;

    p_cfg_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && sel == SEL_CFG) |=> (c_q.en == $past(wr_en_bit)));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && sel == SEL_CFG) |=> $stable(c_q.en));

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (c_q.en && count_q != '0));
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int                DEPTH    = 8,
    parameter int                ADDR_W   = 12,
    parameter logic [31:0]       SENTINEL = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fill_valid,
    input  logic [31:0]       fill_data,
    output logic              fill_ready,
    input  logic [31:0]       peer_status,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [31:0]   head;
    logic [CW-1:0] count_q;
    logic [CW-1:0] count_d;
    logic          pop_en;
    logic          push_en;
    logic          unused_wdata;

    assign unused_wdata = ^bus_wdata[31:1];
    assign fill_ready   = (count_q != CW'(DEPTH));
    assign push_en      = fill_valid && fill_ready;

    mbx_store #(
        .DEPTH    (DEPTH),
        .DW       (WORD_W),
        .SENTINEL (SENTINEL)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_word (fill_data),
        .pop_en    (pop_en),
        .head      (head),
        .count_q   (count_q),
        .count_d   (count_d)
    );

    mbx_regs #(
        .DEPTH    (DEPTH),
        .ADDR_W   (ADDR_W),
        .SENTINEL (SENTINEL)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .wr_en_bit   (bus_wdata[0]),
        .head        (head),
        .count_q     (count_q),
        .count_d     (count_d),
        .peer_status (peer_status),
        .bus_rdata   (bus_rdata),
        .pop_en      (pop_en),
        .irq         (irq)
    );

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && decode_off(bus_addr[7:0]) == SEL_POP
         && count_q == '0 && !fill_valid) |=> (count_q == '0));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_ready && !pop_en) |=> $stable(count_q));
endmodule

// File: tb/mbx_mailbox_tb.sv
module mbx_mailbox_tb;
    localparam int          D    = 4;
    localparam int          AW   = 12;
    localparam logic [31:0] SENT = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          fill_valid = 1'b0;
    logic [31:0]   fill_data = '0;
    logic          fill_ready;
    logic [31:0]   peer_status = '0;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    mbx_mailbox #(.DEPTH(D), .ADDR_W(AW), .SENTINEL(SENT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready),
        .peer_status(peer_status), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = wd;
        #2 rd = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic push(input logic [31:0] d);
        fill_valid = 1'b1; fill_data = d;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    function automatic logic [31:0] stat_of(input int lvl);
        logic [31:0] s;
        s = 32'(lvl);
        if (lvl == D) s[31] = 1'b1;
        if (lvl == 0) s[30] = 1'b1;
        return s;
    endfunction

    function automatic logic [31:0] word_of(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0101_0101;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        access(1'b0, 12'h098, 0, r); check("R1 status", r, stat_of(0));
        access(1'b0, 12'h09C, 0, r); check("R1 config", r, 32'h0);
        access(1'b0, 12'h090, 0, r); check("R1 peek sentinel", r, SENT);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 fill_ready", {31'b0, fill_ready}, 32'h1);

        // R2/R6/R5 fill sweep through every level
        for (int l = 0; l <= D; l++) begin
            access(1'b0, 12'h098, 0, r); check("R6 status level", r, stat_of(l));
            check("R2 fill_ready", {31'b0, fill_ready}, (l == D) ? 32'h0 : 32'h1);
            access(1'b0, 12'h090, 0, r); check("R5 peek head", r, (l == 0) ? SENT : word_of(0));
            if (l < D) push(word_of(l));
        end
        push(32'hDEAD_BEEF);
        access(1'b0, 12'h098, 0, r); check("R2 fill while full dropped", r, stat_of(D));

        // R10 writes to pop offsets and other offsets have no effect
        access(1'b1, 12'h080, 32'h0, r);
        access(1'b1, 12'h098, 32'h0, r);
        access(1'b0, 12'h098, 0, r); check("R10 write ignored status", r, stat_of(D));
        access(1'b0, 12'h094, 0, r); check("R10 sender reads zero", r, 32'h0);
        access(1'b0, 12'h0A0, 0, r); check("R10 unlisted reads zero", r, 32'h0);
        access(1'b0, 12'h099, 0, r); check("R10 unaligned reads zero", r, 32'h0);
        access(1'b0, 12'hF98, 0, r); check("R10 high bits ignored", r, stat_of(D));

        // R3 drain in order using all four pop offsets
        for (int l = D; l > 0; l--) begin
            access(1'b0, 12'h080 + 12'(4 * ((D - l) % 4)), 0, r);
            check("R3 pop order", r, word_of(D - l));
            access(1'b0, 12'h098, 0, r); check("R3 status after pop", r, stat_of(l - 1));
            access(1'b0, 12'h090, 0, r);
            check("R5 peek after pop", r, (l == 1) ? SENT : word_of(D - l + 1));
        end

        // R4 pop on empty
        access(1'b0, 12'h084, 0, r); check("R4 empty pop sentinel", r, SENT);
        access(1'b0, 12'h098, 0, r); check("R4 empty unchanged", r, stat_of(0));

        // R7/R8 config and interrupt
        access(1'b1, 12'h09C, 32'hFFFF_FFFF, r);
        access(1'b0, 12'h09C, 0, r); check("R7 only enable bit written", r, 32'h1);
        check("R8 irq off when empty", {31'b0, irq}, 32'h0);
        push(32'hCAFE_0001);
        check("R8 irq after fill", {31'b0, irq}, 32'h1);
        access(1'b0, 12'h09C, 0, r); check("R7 pending bit", r, 32'h11);
        access(1'b1, 12'h39C, 32'h0, r);
        check("R8 irq after disable", {31'b0, irq}, 32'h0);
        access(1'b0, 12'h09C, 0, r); check("R7 disabled config", r, 32'h10);
        access(1'b1, 12'h09C, 32'h1, r);
        check("R8 irq re-enabled", {31'b0, irq}, 32'h1);
        access(1'b0, 12'h088, 0, r); check("R3 pop single", r, 32'hCAFE_0001);
        check("R8 irq after drain", {31'b0, irq}, 32'h0);

        // R9 peer status pass-through
        peer_status = 32'hA5A5_1234;
        access(1'b0, 12'h0B8, 0, r); check("R9 peer status", r, 32'hA5A5_1234);

        // R11 simultaneous fill and pop
        push(32'h0000_00AA);
        push(32'h0000_00BB);
        fill_valid = 1'b1; fill_data = 32'h0000_00CC;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h08C;
        #2 r = bus_rdata;
        @(posedge clk); #1;
        fill_valid = 1'b0; bus_valid = 1'b0;
        check("R11 popped word", r, 32'h0000_00AA);
        access(1'b0, 12'h098, 0, r); check("R11 count kept", r, stat_of(2));
        access(1'b0, 12'h080, 0, r); check("R11 order first", r, 32'h0000_00BB);
        access(1'b0, 12'h080, 0, r); check("R11 order second", r, 32'h0000_00CC);
        access(1'b0, 12'h090, 0, r); check("R11 drained peek", r, SENT);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule